// File: doc/BRIEF.md
# Configurable Burst Read Controller

This block sequences reads from a burst-capable memory array. A 16-bit configuration word, written through a single-cycle load port, sets its behaviour. The word picks between single-word asynchronous reads and synchronous bursts. It also sets how many clock edges pass between the address strobe and the first data word, and which level of the ready output counts as active. Further fields set whether ready leads each word by one cycle or arrives with it, whether the address wraps inside an aligned block, and how many words a burst delivers.

When chip enable is high, an address strobe captures a starting word address. In burst mode the controller waits out the programmed latency. It then raises the array read enable once per word and presents each word address in turn. Ready follows the chosen timing and polarity. Dropping chip enable ends any burst at once. A fresh strobe drops the burst in progress and starts a new one. Neither action touches the configuration word.

Top module: `burst_rd_ctrl`

## Requirements
- R1: After reset the configuration word is 0xAD08. The block is then in asynchronous mode, `rd_en_o` is 0 and `rdy_o` rests at 0, the inactive level for the default active-high polarity.
- R2: With bit 15 = 1 (asynchronous), a strobe sampled at edge 0 gives `rd_en_o` = 1 with `rd_addr_o` = strobe address for the single cycle after edge 0. Ready stays inactive.
- R3: With bit 15 = 0, let c = bits 13:11 (codes 6 and 7 are treated as 5) and N = c + 2. `rd_en_o` first goes high in the cycle after edge N-1 counted from the strobe edge, so an array sampling on edge N sees the first word.
- R4: Bit 10 sets ready polarity. With 1, `rdy_o` is high when active. With 0, `rdy_o` is low when active. Ready always rests at the inactive level.
- R5: With bit 8 = 0 and c not 0, ready is active in the cycle before each word cycle. With bit 8 = 1, ready is active in exactly the word cycles.
- R6: With c = 0, ready is active in exactly the word cycles, whatever bit 8 holds.
- R7: Bits 2:0 set the burst length L: 010 gives 8, 011 gives 16, 100 gives 32. A fixed burst delivers exactly L consecutive word cycles and then idles. 000 and every other code give an unbounded burst.
- R8: With bit 3 = 1 and a fixed L, word j reads from (start with its low log2(L) bits cleared) OR ((start + j) mod L).
- R9: With bit 3 = 0 or an unbounded burst, word j reads from start + j modulo 2^ADDR_W.
- R10: When `ce_i` is 0 at an edge, the cycle after it has `rd_en_o` = 0 and ready inactive. A strobe is ignored while `ce_i` is 0.
- R11: A strobe during a burst ends that burst. `rd_en_o` is 0 in the following cycle, and the new burst then runs from the new address as in R3.
- R12: The configuration word changes only on reset or a load. A burst after a chip-enable drop, with no reload, behaves as the loaded word says.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for the configuration word |
| cfg_wdata_i | input | 16 | Configuration word to load |
| ce_i | input | 1 | Chip enable, active high |
| addr_vld_i | input | 1 | Address strobe, active high |
| addr_i | input | ADDR_W | Starting word address |
| rd_en_o | output | 1 | Array read enable, one cycle per word |
| rd_addr_o | output | ADDR_W | Word address for the current read |
| rdy_o | output | 1 | Ready, polarity and timing set by configuration |

## Verification
A latency counter that is off by one moves the first `rd_en_o` pulse, and that shows on the very first word of any burst. A beat counter or wrap mask that is wrong only shows when the burst reaches its length or its aligned block boundary. That happens 8 to 32 word cycles in, so the sweep runs every length past its end and starts each burst at a changing offset inside its block. Corrupted ready timing or polarity shows in the first cycle before or at the first word. A configuration register that resets or drifts shows as a changed latency on the next burst.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int CFG_W  = 16;
  localparam int BEAT_W = 6;
  localparam int WAIT_W = 3;
  localparam logic [CFG_W-1:0] CFG_RST = 16'hAD08;

  typedef struct packed {
    logic              sync_en;
    logic [WAIT_W-1:0] wait_edges;  // first-data edge minus two
    logic              rdy_hi;
    logic              rdy_lead;
    logic              wrap;
    logic [BEAT_W-1:0] blen;        // 0 = unbounded
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ISSUE} st_e;

  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] r);
    cfg_t c;
    logic [WAIT_W-1:0] lc;
    lc = (r[13:11] > 3'd5) ? 3'd5 : r[13:11];
    c.sync_en    = ~r[15];
    c.wait_edges = lc;
    c.rdy_hi     = r[10];
    c.rdy_lead   = ~r[8] && (lc != '0);
    c.wrap       = r[3];
    case (r[2:0])
      3'd2:    c.blen = 6'd8;
      3'd3:    c.blen = 6'd16;
      3'd4:    c.blen = 6'd32;
      default: c.blen = 6'd0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
  import brc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_decode(cfg_q);

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/brc_addr_step.sv
module brc_addr_step
  import brc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wrap_i,
  input  logic [BEAT_W-1:0] blen_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] lin;

  always_comb begin
    lin  = addr_i + 1'b1;
    mask = (wrap_i && blen_i != '0) ? ADDR_W'(blen_i - 1'b1) : '0;
    if (mask != '0) addr_o = (addr_i & ~mask) | (lin & mask);
    else            addr_o = lin;
  end
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic              ce_i,
  input  logic              avd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rdy_act_o
);
  st_e               state_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] cur_q, nxt;
  logic              en_q, sync_word_q;

  brc_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (cur_q),
    .wrap_i (cfg_i.wrap),
    .blen_i (cfg_i.blen),
    .addr_o (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wcnt_q      <= '0;
      beat_q      <= '0;
      cur_q       <= '0;
      en_q        <= 1'b0;
      sync_word_q <= 1'b0;
      rd_addr_o   <= '0;
    end else if (!ce_i) begin
      state_q     <= ST_IDLE;
      en_q        <= 1'b0;
      sync_word_q <= 1'b0;
    end else if (avd_i) begin
      sync_word_q <= 1'b0;
      if (cfg_i.sync_en) begin
        cur_q  <= addr_i;
        beat_q <= '0;
        en_q   <= 1'b0;
        wcnt_q <= cfg_i.wait_edges;
        state_q <= (cfg_i.wait_edges == '0) ? ST_ISSUE : ST_WAIT;
      end else begin
        state_q   <= ST_IDLE;
        en_q      <= 1'b1;
        rd_addr_o <= addr_i;
      end
    end else begin
      en_q        <= (state_q == ST_ISSUE);
      sync_word_q <= (state_q == ST_ISSUE);
      rd_addr_o   <= cur_q;
      case (state_q)
        ST_WAIT: begin
          wcnt_q <= wcnt_q - 1'b1;
          if (wcnt_q == WAIT_W'(1)) state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cur_q  <= nxt;
          beat_q <= beat_q + 1'b1;
          if (cfg_i.blen != '0 && beat_q == cfg_i.blen - 1'b1) state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign rd_en_o   = en_q;
  assign rdy_act_o = cfg_i.rdy_lead ? (state_q == ST_ISSUE) : sync_word_q;

  // R10
  deselect_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (!rd_en_o && !rdy_act_o));
  // R2
  async_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && avd_i && !cfg_i.sync_en) |=> (rd_en_o && !rdy_act_o && rd_addr_o == $past(addr_i)));
  // R5
  lead_precedes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.rdy_lead && rdy_act_o && ce_i && !avd_i) |=> rd_en_o);
  // R7
  beat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ISSUE && cfg_i.blen != '0) |-> (beat_q < cfg_i.blen));
endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
  import brc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              ce_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rdy_o
);
  cfg_t              cfg;
  logic              rdy_act;
  logic [ADDR_W-1:0] blk_mask;

  brc_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  brc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .ce_i      (ce_i),
    .avd_i     (addr_vld_i),
    .addr_i    (addr_i),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .rdy_act_o (rdy_act)
  );

  assign rdy_o    = cfg.rdy_hi ? rdy_act : ~rdy_act;
  assign blk_mask = ADDR_W'(cfg.blen - 1'b1);

  // R8
  wrap_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o) && cfg.sync_en && cfg.wrap && cfg.blen != '0)
      |-> (((rd_addr_o ^ $past(rd_addr_o)) & ~blk_mask) == '0));
endmodule

// File: tb/burst_rd_ctrl_tb.sv
`timescale 1ns/1ps
module burst_rd_ctrl_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [15:0]   wdata = '0;
  logic          ce = 1'b1;
  logic          avd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          rdy;
  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  burst_rd_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .ce_i(ce), .addr_vld_i(avd), .addr_i(addr),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rdy_o(rdy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  // strobe at edge 0, check every cycle k after edge k, then deselect
  task automatic run_burst(input logic [15:0] c, input logic [AW-1:0] s, input string xt);
    int code, n, len, pol, lead, wrap, j, e_en, e_act, e_adr;
    code = int'(c[13:11]); if (code > 5) code = 5;
    n = code + 2;
    case (c[2:0]) 3'd2: len = 8; 3'd3: len = 16; 3'd4: len = 32; default: len = 0; endcase
    pol = int'(c[10]); lead = (!c[8] && code != 0) ? 1 : 0; wrap = int'(c[3]);
    @(negedge clk); avd = 1'b1; addr = s;
    for (int k = 0; k <= n + 36; k++) begin
      @(negedge clk); avd = 1'b0;
      e_en = (k >= n - 1 && (len == 0 || k <= n - 2 + len)) ? 1 : 0;
      e_act = lead ? ((k >= n - 2 && (len == 0 || k <= n - 3 + len)) ? 1 : 0) : e_en;
      chk((k == n - 1) ? {"R3 rd_en ", xt} : {"R7 rd_en ", xt}, int'(rd_en), e_en);
      chk(lead ? {"R5 rdy ", xt} : ((code == 0 && !c[8]) ? {"R6 rdy ", xt} : {"R4 rdy ", xt}),
          int'(rdy), pol ? e_act : 1 - e_act);
      if (e_en == 1) begin
        j = k - (n - 1);
        if (wrap == 1 && len != 0)
          e_adr = (int'(s) & ~(len - 1)) | ((int'(s) + j) & (len - 1));
        else
          e_adr = (int'(s) + j) & 16'hFFFF;
        chk((wrap == 1 && len != 0) ? {"R8 addr ", xt} : {"R9 addr ", xt}, int'(rd_addr), e_adr);
      end
    end
    ce = 1'b0; avd = 1'b1;
    @(negedge clk);
    chk("R10 rd_en after deselect", int'(rd_en), 0);
    chk("R10 rdy after deselect", int'(rdy), pol ? 0 : 1);
    @(negedge clk);
    chk("R10 strobe ignored while deselected", int'(rd_en), 0);
    ce = 1'b1; avd = 1'b0;
  endtask

  task automatic async_read(input logic [AW-1:0] s, input int inact, input string tag);
    @(negedge clk); avd = 1'b1; addr = s;
    @(negedge clk); avd = 1'b0;
    chk({tag, " async rd_en"}, int'(rd_en), 1);
    chk({tag, " async addr"}, int'(rd_addr), int'(s));
    chk({tag, " async rdy"}, int'(rdy), inact);
    @(negedge clk);
    chk({tag, " async pulse width"}, int'(rd_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int idx;
    logic [15:0] c;
    repeat (3) @(negedge clk);
    chk("R1 reset rd_en", int'(rd_en), 0);
    chk("R1 reset rdy", int'(rdy), 0);
    rst_n = 1'b1;
    async_read(16'h0ABC, 0, "R1 R2");
    load(16'h8000);
    async_read(16'h1357, 1, "R2 R4");

    idx = 0;
    for (int lat = 0; lat < 8; lat++)
      for (int pol = 0; pol < 2; pol++)
        for (int ld = 0; ld < 2; ld++)
          for (int wr = 0; wr < 2; wr++)
            for (int bl = 0; bl < 8; bl++) begin
              c = 16'((lat << 11) | (pol << 10) | (ld << 8) | (wr << 3) | bl);
              load(c);
              run_burst(c, 16'(16'hFFE3 + idx * 37), "sweep");
              idx++;
            end

    // R12: config survives deselect, no reload
    c = 16'h1D0B;
    load(c);
    run_burst(c, 16'h2006, "R12 first");
    run_burst(c, 16'h3019, "R12 after deselect");

    // R11: restart mid-burst
    c = 16'h1C0C;
    load(c);
    @(negedge clk); avd = 1'b1; addr = 16'h4000;
    @(negedge clk); avd = 1'b0;
    repeat (7) @(negedge clk);
    chk("R11 burst running", int'(rd_en), 1);
    run_burst(c, 16'h5011, "R11 restart");

    // R1: reset returns default asynchronous mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    async_read(16'h7777, 0, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule